// File: doc/BRIEF.md
# Optical Disc Sector Framer

This block turns a multi-sector read command into the byte stream a host receives from an optical data disc. It supports two sector layouts. In cooked layout only the user data of each sector is sent. In raw layout each user-data block is wrapped in a full frame built on the fly: a synchronisation pattern, a minute/second/frame address derived from the block address, a mode byte, the user data, and a zero-filled error-correction area. Error-correction values are not computed. Media access is also outside this block: user data arrives on a byte input with valid/ready handshaking.

A command carries a start block address, a sector count and a request byte. The request byte selects no transfer, cooked layout or raw layout, or it is rejected as an illegal request. Each command ends with a one-cycle completion pulse. A completion flag on that pulse marks a rejected request. The output stream has valid/ready handshaking and a last flag. User bytes pass straight through, so the user-data input is stalled while the framer inserts its own bytes.

Top module: `cd_sector_framer`

## Requirements
- R1: In cooked layout each sector is exactly USER_BYTES (default 2048) bytes, equal to the user-data input bytes in arrival order.
- R2: In raw layout byte 0 of every frame is 0x00 and bytes 1 to 11 are 0xFF.
- R3: In raw layout, frame bytes 12, 13 and 14 are the binary minute (low 8 bits), second and frame of n = block address + 150, where minute = (n/75)/60, second = (n/75)%60 and frame = n%75. Byte 15 is 0x01.
- R4: In raw layout, frame bytes 16 up to 16+USER_BYTES-1 carry the user data in order. ECC_BYTES (default 288) bytes of 0x00 follow, so the default frame is 2352 bytes.
- R5: The address in the raw header advances by one block for each successive sector of a command.
- R6: The request byte is ANDed with 0xF8. A result of 0x00 completes with no data. 0x10 selects cooked layout. 0xF8 selects raw layout. Any other result completes with the illegal flag set and no data.
- R7: A sector count of zero completes successfully with no data, whatever the request byte holds.
- R8: A command emits exactly count × sector-size bytes. The last flag is high only on the final byte of the final sector.
- R9: The user-data input is ready only while a user byte is due and the output is ready. Exactly count × USER_BYTES input bytes are consumed per command.
- R10: Commands are accepted only while idle. The completion pulse comes in the cycle after the final output byte is accepted, or in the cycle after a command that moves no data is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_lba | input | ADDR_W | Starting block address |
| cmd_count | input | COUNT_W | Number of sectors |
| cmd_req | input | 8 | Request byte choosing the layout |
| in_data | input | 8 | User-data byte |
| in_valid | input | 1 | User-data byte present |
| in_ready | output | 1 | User-data byte taken |
| out_data | output | 8 | Output stream byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink accepts output byte |
| out_last | output | 1 | Final byte of the command |
| done_pulse | output | 1 | One-cycle command completion |
| done_illegal | output | 1 | With done_pulse: request byte rejected |

## Verification
Output bytes have no fixed latency. A byte is due in whichever cycle both out_valid and out_ready are high. The bench therefore compares every byte against an arithmetic model indexed by how many bytes have been accepted, not by cycle count. The completion pulse is due exactly one cycle after the accepting handshake. That handshake is either the final byte or the acceptance of a no-data or rejected command. Inputs change on the falling edge, and all sampling happens a quarter period later, before the rising edge that commits the handshake. Each check therefore sees exactly the values that edge will act on.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
   localparam int SYNC_LEN   = 12;
   localparam int HDR_LEN    = 4;
   localparam int LEAD_IN    = 150;
   localparam int FRAMES_PS  = 75;
   localparam int SECS_PM    = 60;
   localparam logic [7:0] MODE_BYTE  = 8'h01;
   localparam logic [7:0] REQ_MASK   = 8'hF8;
   localparam logic [7:0] REQ_NONE   = 8'h00;
   localparam logic [7:0] REQ_COOKED = 8'h10;
   localparam logic [7:0] REQ_RAW    = 8'hF8;

   typedef enum logic [1:0] {ACT_NONE, ACT_COOKED, ACT_RAW, ACT_BAD} act_t;
   typedef enum logic [1:0] {ST_IDLE, ST_SEED, ST_STREAM} st_t;
   typedef enum logic [1:0] {PH_IDLE, PH_FRAME, PH_MINSEC} phase_t;
endpackage

// File: rtl/cdf_req_decode.sv
module cdf_req_decode
   import cdf_pkg::*;
#(
   parameter int COUNT_W = 24
) (
   input  logic [COUNT_W-1:0] count,
   input  logic [7:0]         req,
   output act_t               act
);
   logic [7:0] masked;
   assign masked = req & REQ_MASK;

   always_comb begin
      if (count == '0) begin
         act = ACT_NONE;           // zero count wins over the request byte
      end else begin
         unique case (masked)
            REQ_NONE:   act = ACT_NONE;
            REQ_COOKED: act = ACT_COOKED;
            REQ_RAW:    act = ACT_RAW;
            default:    act = ACT_BAD;
         endcase
      end
   end
endmodule

// File: rtl/cdf_serdiv.sv
module cdf_serdiv #(
   parameter int W  = 33,
   parameter int DW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [W-1:0]  num,
   input  logic [DW-1:0] den,
   output logic          fin,
   output logic [W-1:0]  quo,
   output logic [DW-1:0] rem
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  acc;
   logic [DW-1:0] r;
   logic [DW-1:0] d;
   logic [CW-1:0] cnt;
   logic          run;
   logic [DW:0]   trial;
   logic          ge;
   logic [DW-1:0] nxt_r;

   assign trial = {r, acc[W-1]};
   assign ge    = trial >= {1'b0, d};
   assign nxt_r = ge ? DW'(trial - {1'b0, d}) : trial[DW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         r   <= '0;
         d   <= '0;
         cnt <= '0;
         run <= 1'b0;
         fin <= 1'b0;
      end else if (go) begin
         acc <= num;
         r   <= '0;
         d   <= den;
         cnt <= CW'(W);
         run <= 1'b1;
         fin <= 1'b0;
      end else if (run) begin
         acc <= {acc[W-2:0], ge};
         r   <= nxt_r;
         cnt <= cnt - CW'(1);
         if (cnt == CW'(1)) begin
            run <= 1'b0;
            fin <= 1'b1;
         end
      end else begin
         fin <= 1'b0;
      end
   end

   assign quo = acc;
   assign rem = r;

   assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (rem < d));
endmodule

// File: rtl/cdf_msf_track.sv
module cdf_msf_track
   import cdf_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_go,
   input  logic [ADDR_W-1:0] seed_lba,
   input  logic              step,
   output logic              rdy,
   output logic [7:0]        mm,
   output logic [7:0]        ss,
   output logic [7:0]        ff
);
   localparam int NW = ADDR_W + 1;   // room for the lead-in offset
   localparam int DW = 7;

   phase_t        phase;
   logic          div_go, div_fin;
   logic [NW-1:0] div_num, div_quo;
   logic [DW-1:0] div_den, div_rem;
   logic [6:0]    fr, sc;
   logic [7:0]    mn;

   assign div_go  = seed_go || (div_fin && phase == PH_FRAME);
   assign div_num = seed_go ? (NW'(seed_lba) + NW'(LEAD_IN)) : div_quo;
   assign div_den = seed_go ? DW'(FRAMES_PS) : DW'(SECS_PM);

   cdf_serdiv #(.W(NW), .DW(DW)) u_div (
      .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
      .fin(div_fin), .quo(div_quo), .rem(div_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         rdy   <= 1'b0;
         fr    <= '0;
         sc    <= '0;
         mn    <= '0;
      end else if (seed_go) begin
         phase <= PH_FRAME;
         rdy   <= 1'b0;
      end else if (div_fin && phase == PH_FRAME) begin
         fr    <= div_rem;
         phase <= PH_MINSEC;
      end else if (div_fin && phase == PH_MINSEC) begin
         sc    <= div_rem;
         mn    <= div_quo[7:0];
         phase <= PH_IDLE;
         rdy   <= 1'b1;
      end else if (step && rdy) begin
         if (fr == 7'(FRAMES_PS - 1)) begin
            fr <= '0;
            if (sc == 7'(SECS_PM - 1)) begin
               sc <= '0;
               mn <= mn + 8'd1;
            end else begin
               sc <= sc + 7'd1;
            end
         end else begin
            fr <= fr + 7'd1;
         end
      end
   end

   assign mm = mn;
   assign ss = {1'b0, sc};
   assign ff = {1'b0, fr};

   assert_msf_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |-> (fr < 7'(FRAMES_PS) && sc < 7'(SECS_PM)));
   assert_msf_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && step && !seed_go && fr != 7'(FRAMES_PS - 1)) |=> (fr == $past(fr) + 7'd1));
endmodule

// File: rtl/cd_sector_framer.sv
module cd_sector_framer
   import cdf_pkg::*;
#(
   parameter int USER_BYTES = 2048,
   parameter int ECC_BYTES  = 288,
   parameter int ADDR_W     = 32,
   parameter int COUNT_W    = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [ADDR_W-1:0]  cmd_lba,
   input  logic [COUNT_W-1:0] cmd_count,
   input  logic [7:0]         cmd_req,
   input  logic [7:0]         in_data,
   input  logic               in_valid,
   output logic               in_ready,
   output logic [7:0]         out_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_last,
   output logic               done_pulse,
   output logic               done_illegal
);
   localparam int RAW_BYTES = SYNC_LEN + HDR_LEN + USER_BYTES + ECC_BYTES;
   localparam int POS_W     = $clog2(RAW_BYTES);
   localparam logic [POS_W-1:0] RAW_END   = POS_W'(RAW_BYTES - 1);
   localparam logic [POS_W-1:0] COOK_END  = POS_W'(USER_BYTES - 1);
   localparam logic [POS_W-1:0] P_MIN     = POS_W'(SYNC_LEN);
   localparam logic [POS_W-1:0] P_SEC     = POS_W'(SYNC_LEN + 1);
   localparam logic [POS_W-1:0] P_FRM     = POS_W'(SYNC_LEN + 2);
   localparam logic [POS_W-1:0] P_MODE    = POS_W'(SYNC_LEN + 3);
   localparam logic [POS_W-1:0] USER_LO   = POS_W'(SYNC_LEN + HDR_LEN);
   localparam logic [POS_W-1:0] USER_LAST = POS_W'(SYNC_LEN + HDR_LEN + USER_BYTES - 1);

   generate
      if (USER_BYTES < 1) begin : g_chk_user
         $error("USER_BYTES must be at least 1");
      end
      if (ECC_BYTES < 0) begin : g_chk_ecc
         $error("ECC_BYTES must not be negative");
      end
      if (ADDR_W < 8) begin : g_chk_addr
         $error("ADDR_W must be at least 8");
      end
      if (COUNT_W < 1) begin : g_chk_count
         $error("COUNT_W must be at least 1");
      end
   endgenerate

   st_t                st;
   act_t               act;
   logic               raw_q;
   logic [POS_W-1:0]   pos;
   logic [COUNT_W-1:0] left;
   logic               done_q, bad_q;
   logic [POS_W-1:0]   sect_end;
   logic               in_user, streaming, beat;
   logic               msf_go, msf_step, msf_rdy;
   logic [7:0]         hdr_mm, hdr_ss, hdr_ff;

   cdf_req_decode #(.COUNT_W(COUNT_W)) u_dec (
      .count(cmd_count), .req(cmd_req), .act(act)
   );

   assign cmd_ready = (st == ST_IDLE);
   assign streaming = (st == ST_STREAM);
   assign sect_end  = raw_q ? RAW_END : COOK_END;
   assign in_user   = !raw_q || (pos >= USER_LO && pos <= USER_LAST);
   assign out_valid = streaming && (in_user ? in_valid : 1'b1);
   assign in_ready  = streaming && in_user && out_ready;
   assign beat      = out_valid && out_ready;
   assign out_last  = streaming && (pos == sect_end) && (left == COUNT_W'(1));
   assign msf_go    = cmd_ready && cmd_valid && (act == ACT_RAW);
   assign msf_step  = beat && raw_q && (pos == sect_end);

   cdf_msf_track #(.ADDR_W(ADDR_W)) u_msf (
      .clk(clk), .rst_n(rst_n), .seed_go(msf_go), .seed_lba(cmd_lba),
      .step(msf_step), .rdy(msf_rdy), .mm(hdr_mm), .ss(hdr_ss), .ff(hdr_ff)
   );

   always_comb begin
      out_data = in_data;
      if (raw_q) begin
         if (pos < P_MIN)        out_data = (pos == '0) ? 8'h00 : 8'hFF;
         else if (pos == P_MIN)  out_data = hdr_mm;
         else if (pos == P_SEC)  out_data = hdr_ss;
         else if (pos == P_FRM)  out_data = hdr_ff;
         else if (pos == P_MODE) out_data = MODE_BYTE;
         else if (!in_user)      out_data = 8'h00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         raw_q  <= 1'b0;
         pos    <= '0;
         left   <= '0;
         done_q <= 1'b0;
         bad_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         bad_q  <= 1'b0;
         unique case (st)
            ST_IDLE: if (cmd_valid) begin
               unique case (act)
                  ACT_NONE: done_q <= 1'b1;
                  ACT_BAD: begin
                     done_q <= 1'b1;
                     bad_q  <= 1'b1;
                  end
                  ACT_COOKED: begin
                     raw_q <= 1'b0;
                     pos   <= '0;
                     left  <= cmd_count;
                     st    <= ST_STREAM;
                  end
                  ACT_RAW: begin
                     raw_q <= 1'b1;
                     pos   <= '0;
                     left  <= cmd_count;
                     st    <= ST_SEED;
                  end
               endcase
            end
            ST_SEED: if (msf_rdy) st <= ST_STREAM;
            ST_STREAM: if (beat) begin
               if (pos == sect_end) begin
                  pos  <= '0;
                  left <= left - COUNT_W'(1);
                  if (left == COUNT_W'(1)) begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end else begin
                  pos <= pos + POS_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done_pulse   = done_q;
   assign done_illegal = bad_q;

   assert_input_follows_sink_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> out_ready);
   assert_last_completes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_last && out_valid && out_ready) |=> (cmd_ready && done_pulse));
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (!out_valid && !in_ready));
   assert_illegal_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_illegal |-> done_pulse);
   assert_header_seeded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && raw_q && pos == P_MIN) |-> msf_rdy);
   assert_pos_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      streaming |-> (pos <= sect_end));
endmodule

// File: tb/cd_sector_framer_bench.sv
module cd_sector_framer_bench;
   localparam int CLK_P = 10;
   localparam int UB = 8;
   localparam int EB = 4;
   localparam int AW = 16;
   localparam int CW = 4;
   localparam int RB = 16 + UB + EB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [AW-1:0] cmd_lba = '0;
   logic [CW-1:0] cmd_count = '0;
   logic [7:0]    cmd_req = '0;
   logic [7:0]    in_data = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [7:0]    out_data;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic          out_last;
   logic          done_pulse;
   logic          done_illegal;

   int checks = 0;
   int failures = 0;
   int prod_idx = 0;
   int cur_salt = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_P/2) clk = ~clk;

   cd_sector_framer #(.USER_BYTES(UB), .ECC_BYTES(EB), .ADDR_W(AW), .COUNT_W(CW)) u_cd_sector_framer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_lba(cmd_lba), .cmd_count(cmd_count), .cmd_req(cmd_req),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_last(out_last), .done_pulse(done_pulse), .done_illegal(done_illegal)
   );

   function automatic int ubyte(int u, int salt);
      return (u * 37 + salt) & 255;
   endfunction

   function automatic int exp_byte(bit raw, int lba, int i, int salt);
      int sz = raw ? RB : UB;
      int s = i / sz;
      int p = i % sz;
      int n = lba + s + 150;
      if (!raw) return ubyte(s * UB + p, salt);
      if (p == 0) return 0;
      if (p < 12) return 255;
      if (p == 12) return ((n / 75) / 60) & 255;
      if (p == 13) return (n / 75) % 60;
      if (p == 14) return n % 75;
      if (p == 15) return 1;
      if (p < 16 + UB) return ubyte(s * UB + p - 16, salt);
      return 0;
   endfunction

   function automatic string region_tag(bit raw, int s, int p);
      if (!raw) return "R1 cooked data";
      if (p < 12) return "R2 sync";
      if (p < 16) return (s > 0) ? "R5 header advance" : "R3 header";
      return "R4 user/ecc";
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = (lfsr[1:0] != 2'b00);
      out_ready = (lfsr[3:2] != 2'b00);
      in_data   = 8'(ubyte(prod_idx, cur_salt));
   endtask

   task automatic settle();
      #(CLK_P/4);
   endtask

   task automatic run_cmd(input int lba, input int cnt, input int req);
      int  m      = req & 8'hF8;
      bit  nodata = (cnt == 0) || (m == 0);
      bit  bad    = !nodata && (m != 8'h10) && (m != 8'hF8);
      bit  raw    = (m == 8'hF8);
      int  sz     = raw ? RB : UB;
      int  total  = cnt * sz;
      int  oi     = 0;
      int  guard  = 0;
      cur_salt = (lba + 5) & 255;
      prod_idx = 0;
      next_cycle();
      cmd_valid = 1'b1;
      cmd_lba   = AW'(lba);
      cmd_count = CW'(cnt);
      cmd_req   = 8'(req);
      settle();
      chk(cmd_ready == 1'b1, "R10 accept when idle", int'(cmd_ready), 1);
      next_cycle();
      cmd_valid = 1'b0;
      settle();
      if (nodata || bad) begin
         chk(done_pulse == 1'b1 && done_illegal == bad,
             bad ? "R6 illegal request" : ((cnt == 0) ? "R7 zero count" : "R6 no transfer"),
             int'({done_pulse, done_illegal}), int'({1'b1, bad}));
         chk(out_valid == 1'b0 && in_ready == 1'b0, "R6 no data moved", int'(out_valid), 0);
      end else begin
         while (oi < total && guard < 5000) begin
            chk(done_pulse == 1'b0 && cmd_ready == 1'b0, "R10 busy", int'({done_pulse, cmd_ready}), 0);
            if (in_ready) begin
               chk(!raw || ((oi % sz) >= 16 && (oi % sz) < 16 + UB), "R9 stall outside user data",
                   oi % sz, 16);
            end
            if (out_valid && out_ready) begin
               chk(int'(out_data) == exp_byte(raw, lba, oi, cur_salt),
                   region_tag(raw, oi / sz, oi % sz), int'(out_data), exp_byte(raw, lba, oi, cur_salt));
               chk(out_last == (oi == total - 1), "R8 last flag", int'(out_last), int'(oi == total - 1));
               oi++;
            end
            if (in_valid && in_ready) prod_idx++;
            if (oi < total) begin
               next_cycle();
               settle();
               guard++;
            end
         end
         chk(oi == total, "R8 byte count", oi, total);
         next_cycle();
         settle();
         chk(done_pulse == 1'b1 && done_illegal == 1'b0, "R10 completion pulse",
             int'({done_pulse, done_illegal}), 2);
         chk(prod_idx == cnt * UB, "R9 input bytes consumed", prod_idx, cnt * UB);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk(cmd_ready == 1'b1, "R10 reset idle", int'(cmd_ready), 1);
      chk(out_valid == 1'b0 && in_ready == 1'b0 && out_last == 1'b0, "R9 reset quiet",
          int'({out_valid, in_ready, out_last}), 0);
      chk(done_pulse == 1'b0 && done_illegal == 1'b0, "R10 reset no completion",
          int'({done_pulse, done_illegal}), 0);

      // every request byte value, one sector each
      for (int r = 0; r < 256; r++) run_cmd(r * 3, 1, r);
      // zero count wins over any request byte
      run_cmd(10, 0, 8'hF8);
      run_cmd(11, 0, 8'h10);
      run_cmd(12, 0, 8'h55);
      // cooked layout, every count
      for (int c = 1; c < 16; c++) run_cmd(c * 11, c, 8'h10);
      // raw layout sweep across frame and second boundaries
      for (int a = 0; a < 100; a++) run_cmd(a, 2, 8'hF8 | (a & 7));
      // minute boundary
      for (int a = 4345; a < 4355; a++) run_cmd(a, 3, 8'hF8);
      // top of the address range, offset exceeds the address width
      for (int a = 65530; a < 65536; a++) run_cmd(a, 3, 8'hFC);
      run_cmd(1234, 15, 8'hF8);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule